// File: doc/BRIEF.md
# Bus-Programmable Pulse-Width Modulator

This block makes one pulse-width modulated output from a 32-bit up-counter. Software sets it up through a small word-addressed slave port. One register turns the output on and off. A second register sets how long the period lasts, and a third sets how long the output stays high in each period. The counter runs from zero up to the period value and then goes back to zero. The output rises on that return to zero. It falls once the counter has gone past the active threshold.

A new threshold written by software waits in a holding register. It becomes active only when the counter returns to zero, so a period already in progress is never cut short or stretched. Writing a new period value restarts the counter at once. The counter keeps running while the output is switched off, so switching it back on picks up the same phase. Reset is synchronous and active low. Parameters set the values that all three registers take at reset.

Top module: `pwm_mm`

## Requirements
- R1: While reset is held low, the enable, period and threshold registers load the values of the parameters RST_ENABLE, RST_PERIOD and RST_COMPARE. Reading them back right after reset returns those values. The output is low during reset.
- R2: One output period lasts period+1 clock cycles. This means rising edges of `pwm_out` are period+1 cycles apart.
- R3: In each period `pwm_out` is high for threshold+1 consecutive cycles, where the threshold is the active one. This gives a duty cycle of (threshold+1)/(period+1).
- R4: While the enable bit is 0, `pwm_out` stays low. The change takes effect from the second clock after the write.
- R5: A write to the period register (word address 1) clears the counter. As a result `pwm_out` is high two clocks after the write is accepted, when enabled.
- R6: A write to the threshold register (word address 2) goes to a holding register. The active threshold is loaded from it only when the counter wraps from the period value to 0, so the period in progress keeps its old high time.
- R7: While the active threshold is greater than or equal to the period and the block is enabled, `pwm_out` stays high all the time.
- R8: The word address map is: 0 holds the enable in bit 0, 1 holds the period, 2 holds the threshold. Reads return data in the same cycle while `read` is high. Reading address 0 gives the enable in bit 0 and zero in every other bit. Reading address 2 gives the value last written.
- R9: Address 3 reads as zero. A write to address 3 changes no register and does not disturb `pwm_out`.
- R10: The counter keeps running while the block is disabled. After re-enabling, rising edges fall on the same phase grid of period+1 cycles as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| address | input | AW | Word address of the register accessed |
| read | input | 1 | Read strobe; readdata is valid while high |
| write | input | 1 | Write strobe, taken on the rising clock edge |
| writedata | input | DW | Write data |
| readdata | output | DW | Read data, zero when read is low |
| pwm_out | output | 1 | Registered modulated output |

## Verification
The bench builds the block with a reset period of 9, a reset threshold of 4 and the output enabled at reset. This lets many complete periods pass in a short run, and the reset-default values can be seen straight away without any register writes. Because the period is that short, the bench can go on to reprogram it to 7. It can then walk the threshold below the period, equal to it and far above it. It can also write a threshold in the middle of a high phase, switch the output off and on again at an arbitrary phase, and still measure the phase grid over several periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Word offsets of the software-visible registers
  localparam int unsigned SEL_ENABLE    = 0;
  localparam int unsigned SEL_PERIOD    = 1;
  localparam int unsigned SEL_THRESHOLD = 2;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_ENABLE,
    ACC_PERIOD,
    ACC_THRESHOLD
  } acc_kind_e;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter int unsigned AW           = 2,
  parameter logic [DW-1:0] RST_PERIOD  = '0,
  parameter logic [DW-1:0] RST_COMPARE = '0,
  parameter bit          RST_ENABLE   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] address,
  input  logic          read,
  input  logic          write,
  input  logic [DW-1:0] writedata,
  input  logic          wrap,
  output logic [DW-1:0] readdata,
  output logic          enable,
  output logic [DW-1:0] period,
  output logic [DW-1:0] thr_active,
  output logic          period_wr
);
  acc_kind_e      kind;
  logic [DW-1:0]  thr_hold;

  always_comb begin
    kind = ACC_NONE;
    if (address == AW'(SEL_ENABLE))         kind = ACC_ENABLE;
    else if (address == AW'(SEL_PERIOD))    kind = ACC_PERIOD;
    else if (address == AW'(SEL_THRESHOLD)) kind = ACC_THRESHOLD;
  end

  assign period_wr = write && (kind == ACC_PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable     <= RST_ENABLE;
      period     <= RST_PERIOD;
      thr_hold   <= RST_COMPARE;
      thr_active <= RST_COMPARE;
    end else begin
      if (write && kind == ACC_ENABLE)    enable   <= writedata[0];
      if (period_wr)                      period   <= writedata;
      if (write && kind == ACC_THRESHOLD) thr_hold <= writedata;
      if (wrap)                           thr_active <= thr_hold;
    end
  end

  always_comb begin
    readdata = '0;
    if (read) begin
      case (kind)
        ACC_ENABLE:    readdata = {{(DW-1){1'b0}}, enable};
        ACC_PERIOD:    readdata = period;
        ACC_THRESHOLD: readdata = thr_hold;
        default:       readdata = '0;
      endcase
    end
  end

  // The active threshold changes only at a period boundary
  assert_thr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(thr_active));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] period,
  input  logic          clear,
  output logic [DW-1:0] count,
  output logic          wrap
);
  assign wrap = (count == period);

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (clear)      count <= '0;
    else if (wrap)       count <= '0;
    else                 count <= count + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= period);
  assert_period_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] thr_active,
  input  logic [DW-1:0] period,
  output logic          pwm_q
);
  logic level;

  assign level = enable && (count <= thr_active);

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= level;
  end

  assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwm_q);
  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && thr_active >= period) |=> pwm_q);
endmodule

// File: rtl/pwm_mm.sv
module pwm_mm #(
  parameter int unsigned DW           = 32,
  parameter int unsigned AW           = 2,
  parameter logic [DW-1:0] RST_PERIOD  = '0,
  parameter logic [DW-1:0] RST_COMPARE = '0,
  parameter bit          RST_ENABLE   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] address,
  input  logic          read,
  input  logic          write,
  input  logic [DW-1:0] writedata,
  output logic [DW-1:0] readdata,
  output logic          pwm_out
);
  logic          enable;
  logic [DW-1:0] period;
  logic [DW-1:0] thr_active;
  logic          period_wr;
  logic [DW-1:0] count;
  logic          wrap;

  pwm_regfile #(
    .DW(DW), .AW(AW),
    .RST_PERIOD(RST_PERIOD), .RST_COMPARE(RST_COMPARE), .RST_ENABLE(RST_ENABLE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .address(address), .read(read), .write(write),
    .writedata(writedata), .wrap(wrap), .readdata(readdata), .enable(enable),
    .period(period), .thr_active(thr_active), .period_wr(period_wr)
  );

  pwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period(period), .clear(period_wr),
    .count(count), .wrap(wrap)
  );

  pwm_shaper #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count(count),
    .thr_active(thr_active), .period(period), .pwm_q(pwm_out)
  );

  // Output is low throughout reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !pwm_out);
endmodule

// File: tb/test_pwm_mm.sv
module test_pwm_mm;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 50000;
  localparam logic [DW-1:0] P0 = 32'd9;
  localparam logic [DW-1:0] C0 = 32'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] address = '0;
  logic          read = 1'b0;
  logic          write = 1'b0;
  logic [DW-1:0] writedata = '0;
  logic [DW-1:0] readdata;
  logic          pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  pwm_mm #(.DW(DW), .AW(AW), .RST_PERIOD(P0), .RST_COMPARE(C0), .RST_ENABLE(1'b1))
    i_pwm_mm (.clk(clk), .rst_n(rst_n), .address(address), .read(read),
              .write(write), .writedata(writedata), .readdata(readdata),
              .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements; pushes expected output
  logic [DW-1:0] m_cnt, m_per, m_hold, m_act;
  logic          m_en;
  bit            exp_q[$];

  always @(posedge clk) begin
    bit e;
    bit w;
    cyc++;
    if (!rst_n) begin
      e = 1'b0;
      m_en = 1'b1; m_per = P0; m_hold = C0; m_act = C0; m_cnt = '0;
    end else begin
      e = m_en && (m_cnt <= m_act);
      w = (m_cnt == m_per);
      if (write && address == 2'd1) m_cnt = '0;
      else if (w)                   m_cnt = '0;
      else                          m_cnt = m_cnt + 1;
      if (w) m_act = m_hold;
      if (write && address == 2'd0) m_en = writedata[0];
      if (write && address == 2'd1) m_per = writedata;
      if (write && address == 2'd2) m_hold = writedata;
    end
    exp_q.push_back(e);
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      checks++;
      if (pwm_out !== e) begin
        errors++;
        $display("FAIL %s pwm_out cycle %0d: got %b expected %b", cur_req, cyc, pwm_out, e);
      end
    end
  end

  task automatic check_eq(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    address = a; writedata = d; write = 1'b1;
    @(negedge clk);
    write = 1'b0;
  endtask

  task automatic bus_read(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    address = a; read = 1'b1;
    #1;
    check_eq(req, $sformatf("read addr %0d", a), readdata, exp);
    read = 1'b0;
  endtask

  task automatic count_high(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  task automatic wait_rise(output int t);
    bit prev;
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    t = cyc;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int h, t0, t1, r;
    repeat (3) @(negedge clk);
    check_eq("R1", "pwm during reset", {31'd0, pwm_out}, 0);
    rst_n = 1'b1;
    // R1: reset values
    bus_read("R1", 2'd0, 1);
    bus_read("R1", 2'd1, P0);
    bus_read("R1", 2'd2, C0);
    repeat (20) @(negedge clk);

    // R3: high time per period; R2: period length
    cur_req = "R3";
    count_high(10, h); check_eq("R3", "highs per 10-cycle period", h, 5);
    cur_req = "R2";
    wait_rise(t0); wait_rise(t1); check_eq("R2", "rise spacing", t1 - t0, 10);
    count_high(30, h); check_eq("R2", "highs over 3 periods", h, 15);

    // R5: period write clears counter
    cur_req = "R5";
    repeat (7) @(negedge clk);
    bus_write(2'd1, 32'd7);
    @(negedge clk);
    check_eq("R5", "pwm two clocks after period write", {31'd0, pwm_out}, 1);
    count_high(7, h); check_eq("R5", "highs in rest of restarted period", h, 4);
    cur_req = "R8";
    bus_read("R8", 2'd1, 32'd7);

    // R6: threshold buffered until wrap
    cur_req = "R6";
    wait_rise(t0);
    bus_write(2'd2, 32'd2);
    bus_read("R8", 2'd2, 32'd2);
    r = 1 + (pwm_out ? 1 : 0);
    while (pwm_out) begin @(negedge clk); if (pwm_out) r++; end
    check_eq("R6", "high run of period in progress keeps old threshold", r, 5);
    wait_rise(t0);
    r = 1;
    forever begin @(negedge clk); if (!pwm_out) break; r++; end
    check_eq("R6", "high run after wrap uses new threshold", r, 3);
    cur_req = "R2";
    wait_rise(t1); check_eq("R2", "rise spacing period 7", t1 - t0, 8);

    // R7: threshold at or above period
    cur_req = "R7";
    bus_write(2'd2, 32'd7);
    repeat (20) @(negedge clk);
    count_high(16, h); check_eq("R7", "highs with threshold == period", h, 16);
    bus_write(2'd2, 32'd1000);
    repeat (20) @(negedge clk);
    count_high(16, h); check_eq("R7", "highs with threshold > period", h, 16);
    bus_write(2'd2, 32'd2);
    repeat (20) @(negedge clk);

    // R10: phase kept across disable
    cur_req = "R10";
    wait_rise(t0);
    repeat (3) @(negedge clk);
    cur_req = "R4";
    bus_write(2'd0, 32'd0);
    @(negedge clk);
    count_high(19, h); check_eq("R4", "highs while disabled", h, 0);
    bus_read("R4", 2'd0, 0);
    cur_req = "R10";
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read("R8", 2'd0, 1);
    wait_rise(t1); wait_rise(t1);
    check_eq("R10", "rise phase after re-enable mod 8", (t1 - t0) % 8, 0);

    // R9: unused address
    cur_req = "R9";
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read("R9", 2'd3, 0);
    bus_read("R9", 2'd0, 1);
    bus_read("R9", 2'd1, 32'd7);
    bus_read("R9", 2'd2, 32'd2);
    count_high(16, h); check_eq("R9", "highs after unused write", h, 6);
    check_eq("R8", "readdata with read low", readdata, 0);

    done = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule